// File: doc/BRIEF.md
# Microcode Sequencer Address Generator

This block produces the control-store address for a microprogrammed instruction engine. The address is a 13-bit word that packs three fields: an 8-bit opcode page in the upper bits, one subroutine-space bit, and a 4-bit micro-step in the low bits. The instruction opcode is used as the page directly, with no decode step in between.

Every clock cycle the block picks the next address from one of these sources:
- a freshly fetched opcode;
- a short jump that rewrites only the step field;
- a long target taken from a small constant translation table (used by long jumps and by calls);
- a single saved return address;
- the current address plus one.

A call stores the incremented address in a one-entry return register in the same cycle that it redirects. An end-of-instruction micro-op makes the block hold its address and raise a fetch request until the start strobe delivers the next opcode. Jumps can be made conditional on a flag being clear.

Top module: `useqAddrGen`

## Requirements
- R1: The address output is {page[12:5], sub[4], step[3:0]}. A synchronous active-high reset sets it to 0, clears the fetch request and clears the return register.
- R2: When startStb is high, the next address is {opcode, 1'b0, 4'h0}. This overrides every other control, including the wait state, and it clears the fetch request.
- R3: A taken short jump sets bits 3:0 to shortTgt and keeps bits 12:4 unchanged.
- R4: A taken long jump with code c loads the translation entry {4'hF, c[3:0], 1'b1, 4'h0}.
- R5: A call with code c loads the same entry as R4 and, in the same cycle, stores the current address + 1 in the return register. A later call overwrites that value.
- R6: A return loads the value held in the return register.
- R7: With no control active, the address increments by one modulo 2^13. 13'h1FFF goes to 0.
- R8: When condEn is high, a short or long jump is taken only if condFlag is 0. Otherwise the address increments.
- R9: When several controls are high, the order of precedence is start, then short jump, then call, then long jump, then return.
- R10: endOp makes the address hold, and fetchReq is 1 from the next cycle. While fetchReq is 1 the address holds and jumps, calls and returns are ignored, until startStb arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startStb | input | 1 | Start of a new instruction; loads the opcode |
| opcode | input | 8 | Instruction opcode |
| endOp | input | 1 | End-of-instruction micro-op |
| shortJmp | input | 1 | Short in-page jump |
| shortTgt | input | 4 | Step target for a short jump |
| longJmp | input | 1 | Long jump through the translation table |
| callOp | input | 1 | Subroutine call through the translation table |
| retOp | input | 1 | Return to the saved address |
| longCode | input | 4 | Translation table index |
| condEn | input | 1 | Makes a jump conditional on condFlag being clear |
| condFlag | input | 1 | Condition flag, for example carry |
| uAddr | output | 13 | Current micro-address |
| fetchReq | output | 1 | Request for the next opcode |

## Verification
Two functions of this block can fall in the same cycle. The first pair is a call redirecting the address while also saving the return address; the bench then returns after two nested calls and judges that only the second saved value survives. The second pair is the start strobe arriving together with jump or return controls, or arriving during the wait state; the bench drives these together and expects the opcode page to win. Further cycles drive short jump, long jump and return together to confirm the ordering among the lower-priority sources.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef struct packed {
    logic loadOp;
    logic loadStep;
    logic loadLong;
    logic saveRet;
    logic loadRet;
    logic incr;
  } seqStrobe_t;
endpackage

// File: rtl/useqCtrl.sv
module useqCtrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startStb,
  input  logic       endOp,
  input  logic       shortJmp,
  input  logic       longJmp,
  input  logic       callOp,
  input  logic       retOp,
  input  logic       condEn,
  input  logic       condFlag,
  output seqStrobe_t strb,
  output logic       fetchReq
);
  logic waiting;
  logic waitNext;
  logic jmpOk;

  assign jmpOk    = !condEn || !condFlag;
  assign fetchReq = waiting;

  always_comb begin
    strb     = '0;
    waitNext = waiting;
    if (startStb) begin
      strb.loadOp = 1'b1;
      waitNext    = 1'b0;
    end else if (waiting) begin
      waitNext = 1'b1;
    end else if (shortJmp && jmpOk) begin
      strb.loadStep = 1'b1;
    end else if (callOp) begin
      strb.loadLong = 1'b1;
      strb.saveRet  = 1'b1;
    end else if (longJmp && jmpOk) begin
      strb.loadLong = 1'b1;
    end else if (retOp) begin
      strb.loadRet = 1'b1;
    end else if (endOp) begin
      waitNext = 1'b1;
    end else begin
      strb.incr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) waiting <= 1'b0;
    else     waiting <= waitNext;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.loadOp, strb.loadStep, strb.loadLong, strb.loadRet, strb.incr})); // R9
  AST_WAIT_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (waiting && !startStb) |-> (strb == '0)); // R10
  AST_END_WAIT: assert property (@(posedge clk) disable iff (rst)
    (endOp && !startStb && !waiting && !shortJmp && !longJmp && !callOp && !retOp)
      |=> fetchReq); // R10
endmodule

// File: rtl/useqPath.sv
module useqPath
  import useq_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int STEP_W  = 4,
  parameter int TCODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  seqStrobe_t              strb,
  input  logic [OP_W-1:0]         opcode,
  input  logic [STEP_W-1:0]       shortTgt,
  input  logic [TCODE_W-1:0]      longCode,
  output logic [OP_W+STEP_W:0]    uAddr
);
  localparam int ADDR_W = OP_W + 1 + STEP_W;
  localparam int TAB_N  = 1 << TCODE_W;
  localparam int FILL_W = OP_W - TCODE_W;

  logic [ADDR_W-1:0] xlTab [TAB_N];
  logic [ADDR_W-1:0] retReg;
  logic [ADDR_W-1:0] addrInc;

  for (genvar g = 0; g < TAB_N; g++) begin : g_xl
    assign xlTab[g] = {{FILL_W{1'b1}}, TCODE_W'(g), 1'b1, {STEP_W{1'b0}}};
  end

  assign addrInc = uAddr + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      uAddr  <= '0;
      retReg <= '0;
    end else begin
      if (strb.loadOp)        uAddr <= {opcode, 1'b0, {STEP_W{1'b0}}};
      else if (strb.loadStep) uAddr <= {uAddr[ADDR_W-1:STEP_W], shortTgt};
      else if (strb.loadLong) uAddr <= xlTab[longCode];
      else if (strb.loadRet)  uAddr <= retReg;
      else if (strb.incr)     uAddr <= addrInc;
      if (strb.saveRet)       retReg <= addrInc;
    end
  end

  AST_CALL_SAVE: assert property (@(posedge clk) disable iff (rst)
    strb.saveRet |=> (retReg == $past(uAddr) + ADDR_W'(1))); // R5
  AST_RET_LOAD: assert property (@(posedge clk) disable iff (rst)
    strb.loadRet |=> (uAddr == $past(retReg))); // R6
endmodule

// File: rtl/useqAddrGen.sv
module useqAddrGen
  import useq_pkg::*;
#(
  parameter int OP_W    = 8,
  parameter int STEP_W  = 4,
  parameter int TCODE_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 startStb,
  input  logic [OP_W-1:0]      opcode,
  input  logic                 endOp,
  input  logic                 shortJmp,
  input  logic [STEP_W-1:0]    shortTgt,
  input  logic                 longJmp,
  input  logic                 callOp,
  input  logic                 retOp,
  input  logic [TCODE_W-1:0]   longCode,
  input  logic                 condEn,
  input  logic                 condFlag,
  output logic [OP_W+STEP_W:0] uAddr,
  output logic                 fetchReq
);
  localparam int ADDR_W = OP_W + 1 + STEP_W;

  seqStrobe_t strb;

  useqCtrl i_ctrl (
    .clk(clk), .rst(rst), .startStb(startStb), .endOp(endOp),
    .shortJmp(shortJmp), .longJmp(longJmp), .callOp(callOp), .retOp(retOp),
    .condEn(condEn), .condFlag(condFlag), .strb(strb), .fetchReq(fetchReq)
  );

  useqPath #(.OP_W(OP_W), .STEP_W(STEP_W), .TCODE_W(TCODE_W)) i_path (
    .clk(clk), .rst(rst), .strb(strb), .opcode(opcode),
    .shortTgt(shortTgt), .longCode(longCode), .uAddr(uAddr)
  );

  AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
    startStb |=> (uAddr == {$past(opcode), 1'b0, {STEP_W{1'b0}}}) && !fetchReq); // R2
  AST_SHORT_PAGE: assert property (@(posedge clk) disable iff (rst)
    (shortJmp && !startStb && !fetchReq && !(condEn && condFlag))
      |=> (uAddr[ADDR_W-1:STEP_W] == $past(uAddr[ADDR_W-1:STEP_W]))
          && (uAddr[STEP_W-1:0] == $past(shortTgt))); // R3
  AST_WAIT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (fetchReq && !startStb) |=> $stable(uAddr)); // R10
  AST_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (condEn && condFlag && shortJmp && !longJmp && !callOp && !retOp && !startStb && !fetchReq)
      |=> (uAddr == $past(uAddr) + ADDR_W'(1))); // R8
endmodule

// File: tb/test_useqAddrGen.sv
module test_useqAddrGen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startStb = 0, endOp = 0, shortJmp = 0, longJmp = 0;
  logic        callOp = 0, retOp = 0, condEn = 0, condFlag = 0;
  logic [7:0]  opcode = 0;
  logic [3:0]  shortTgt = 0, longCode = 0;
  logic [12:0] uAddr;
  logic        fetchReq;
  int          nChecks = 0;
  int          nFails = 0;

  always #10 clk = ~clk;

  useqAddrGen i_useqAddrGen (
    .clk(clk), .rst(rst), .startStb(startStb), .opcode(opcode), .endOp(endOp),
    .shortJmp(shortJmp), .shortTgt(shortTgt), .longJmp(longJmp), .callOp(callOp),
    .retOp(retOp), .longCode(longCode), .condEn(condEn), .condFlag(condFlag),
    .uAddr(uAddr), .fetchReq(fetchReq)
  );

  function automatic logic [12:0] xl(input logic [3:0] c);
    return {4'hF, c, 1'b1, 4'h0};
  endfunction

  task automatic idle();
    startStb = 0; endOp = 0; shortJmp = 0; longJmp = 0;
    callOp = 0; retOp = 0; condEn = 0; condFlag = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
    idle();
  endtask

  task automatic chkA(input string req, input logic [12:0] exp);
    nChecks++;
    if (uAddr !== exp) begin
      nFails++;
      $display("FAIL %s uAddr actual=%h expected=%h", req, uAddr, exp);
    end
  endtask

  task automatic chkF(input string req, input logic exp);
    nChecks++;
    if (fetchReq !== exp) begin
      nFails++;
      $display("FAIL %s fetchReq actual=%b expected=%b", req, fetchReq, exp);
    end
  endtask

  task automatic loadOp(input logic [7:0] op);
    opcode = op; startStb = 1; tick();
  endtask

  task automatic tReset();
    rst = 1; tick(); tick(); rst = 0;
    chkA("R1", 13'h0); chkF("R1", 1'b0);
  endtask

  task automatic tIncrement();
    tick(); chkA("R7", 13'h1);
    tick(); chkA("R7", 13'h2);
  endtask

  task automatic tStartShort();
    loadOp(8'hA5); chkA("R2", 13'h14A0);
    shortTgt = 4'h9; shortJmp = 1; tick(); chkA("R3", 13'h14A9);
  endtask

  task automatic tLong();
    longCode = 4'h3; longJmp = 1; tick(); chkA("R4", xl(4'h3));
  endtask

  task automatic tCallRet();
    loadOp(8'h12); chkA("R2", 13'h240);
    tick(); chkA("R7", 13'h241);
    longCode = 4'h5; callOp = 1; tick(); chkA("R5", xl(4'h5));
    tick(); chkA("R7", xl(4'h5) + 13'h1);
    retOp = 1; tick(); chkA("R6", 13'h242);
    longCode = 4'h1; callOp = 1; tick(); chkA("R5", xl(4'h1));
    longCode = 4'h2; callOp = 1; tick(); chkA("R5", xl(4'h2));
    retOp = 1; tick(); chkA("R5_overwrite", xl(4'h1) + 13'h1);
  endtask

  task automatic tCond();
    loadOp(8'h30);
    condEn = 1; condFlag = 1; shortJmp = 1; shortTgt = 4'h7; tick();
    chkA("R8", 13'h601);
    condEn = 1; condFlag = 0; shortJmp = 1; shortTgt = 4'h7; tick();
    chkA("R8", 13'h607);
    condEn = 1; condFlag = 1; longJmp = 1; longCode = 4'h6; tick();
    chkA("R8", 13'h608);
  endtask

  task automatic tPriority();
    loadOp(8'h40);
    shortJmp = 1; shortTgt = 4'hC; longJmp = 1; longCode = 4'h7; retOp = 1; tick();
    chkA("R9", 13'h80C);
    longJmp = 1; longCode = 4'h7; retOp = 1; tick();
    chkA("R9", xl(4'h7));
    opcode = 8'h55; startStb = 1; shortJmp = 1; shortTgt = 4'h3; retOp = 1; tick();
    chkA("R9", 13'h0AA0);
  endtask

  task automatic tWait();
    loadOp(8'h21);
    endOp = 1; tick(); chkA("R10", 13'h420); chkF("R10", 1'b1);
    shortJmp = 1; shortTgt = 4'h5; tick(); chkA("R10", 13'h420); chkF("R10", 1'b1);
    retOp = 1; tick(); chkA("R10", 13'h420);
    opcode = 8'h22; startStb = 1; tick(); chkA("R2", 13'h440); chkF("R2", 1'b0);
    tick(); chkA("R7", 13'h441);
  endtask

  task automatic tWrap();
    loadOp(8'hFF);
    shortJmp = 1; shortTgt = 4'hF; tick(); chkA("R3", 13'h1FEF);
    tick(); chkA("R7", 13'h1FF0);
    shortJmp = 1; shortTgt = 4'hF; tick(); chkA("R3", 13'h1FFF);
    tick(); chkA("R7_wrap", 13'h0000);
  endtask

  initial begin
    #3;
    tReset();
    tIncrement();
    tStartShort();
    tLong();
    tCallRet();
    tCond();
    tPriority();
    tWait();
    tWrap();
    tReset();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule